// File: doc/BRIEF.md
# Power-Off Event Detector

This block runs beside a system power sequencer and decides, while the system is on, when a shutdown has to start and for which reason. It watches a debounced power-button level, the application processor's power-good input, a pulsed software power-off request and a reset request held as a level. A hold timer counts millisecond ticks while the button stays pressed. When a shutdown condition is found, the block puts a cause code on `evt_cause` and raises `evt_valid` for one clock cycle.

A three-state machine does the sequencing. `ST_IDLE` is the state while `sys_on` is low. `IDLE->ARMED` happens when `sys_on` rises. `ST_ARMED` checks the causes on every cycle, and `ARMED->FIRED` happens on the first cycle that a cause is present. `ST_FIRED` holds the reported code and reports nothing more. `FIRED->ARMED` happens when the sequencer pulses `timer_clr` during a state change. From any state the machine goes to `ST_IDLE` when `sys_on` falls. Software requests win over the button and power-good causes. A new press restarts the hold timer, and a release cancels it without an event. A press that has already produced a long-press event cannot produce another one until the button is released.

Top module: `pwr_off_detect`

## Requirements
- R1: After reset, `evt_valid` is 0 and `evt_cause` is 0 (no cause).
- R2: In ARMED, the first cycle the button is seen pressed after being released starts the hold timer at zero. Each later cycle with `ms_tick` high adds one. After HOLD_TICKS counted ticks with no release, the next clock edge raises `evt_valid` with cause 2 (long press).
- R3: A release before the count reaches HOLD_TICKS cancels the timer and produces no event. The next press starts counting from zero again.
- R4: After a long-press event, the timer stays saturated and cannot fire again until the button is released. This holds even across a `timer_clr` and a return to ARMED.
- R5: `ap_pgood` sampled low at a clock edge in ARMED raises `evt_valid` at that edge with cause 3 (power-good lost).
- R6: A one-cycle `off_req` pulse is latched. It is reported as cause 4 at the next edge in ARMED and cleared once reported, so a later return to ARMED does not report it again.
- R7: `rst_req` high at an edge in ARMED is reported as cause 5. It is never cleared here, so it is reported again each time the machine returns to ARMED while the request is still high.
- R8: When several causes are present together, the priority is off request (4), then reset request (5), then long press (2), then power-good lost (3).
- R9: `evt_valid` is a single-cycle strobe on entry to FIRED. `evt_cause` keeps the reported code until `timer_clr` or the fall of `sys_on`.
- R10: `timer_clr` high at an edge clears the hold count and the was-pressed flag at that edge. While it is high, the long-press cause is suppressed.
- R11: While `sys_on` is low, no event is reported, the hold count stays at zero, `evt_cause` is 0 and `off_req` pulses are dropped.
- R12: Outside FIRED and with `sys_on` high, `evt_cause` reads 1 (button pressed) in the cycle after the button is sampled pressed, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_on | input | 1 | High while the system is powered on |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| btn_level | input | 1 | Debounced button level, 1 = pressed |
| ap_pgood | input | 1 | Processor power-good, 1 = good |
| off_req | input | 1 | Software power-off request pulse |
| rst_req | input | 1 | Reset request level, cleared by its owner |
| timer_clr | input | 1 | Clears the hold timer and re-arms from FIRED |
| evt_cause | output | 3 | Cause code (0 none, 1 pressed, 2 long, 3 pgood lost, 4 off, 5 reset) |
| evt_valid | output | 1 | One-cycle shutdown event strobe |

## Verification
The assertions assume that `sys_on`, `timer_clr` and the request inputs change only between clock edges and that the reset is released synchronously. They also assume that `timer_clr` is used while the system is on, since the clear-timer property is stated only with `sys_on` high. The stimulus drives every input at the falling edge. It mixes directed cases for each cause and for each priority pairing with a long random phase in which `sys_on` rarely toggles, the button changes often enough to both finish and cancel holds with a short hold time, and the reset request is held for many cycles so that it is reported again after each clear.

// File: rtl/pod_pkg.sv
package pod_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_BUTTON  = 3'd1,
        CAUSE_LONG    = 3'd2,
        CAUSE_PG_LOST = 3'd3,
        CAUSE_OFF_REQ = 3'd4,
        CAUSE_RST_REQ = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } fsm_e;

    localparam int NUM_SRC = 4;

    // Source index order is the priority order: lower index wins.
    function automatic cause_e src_code(input int idx);
        case (idx)
            0:       return CAUSE_OFF_REQ;
            1:       return CAUSE_RST_REQ;
            2:       return CAUSE_LONG;
            default: return CAUSE_PG_LOST;
        endcase
    endfunction

endpackage

// File: rtl/pod_req_latch.sv
module pod_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic set_pulse,
    input  logic taken,
    output logic pend
);
    // Pending flag: a new pulse wins over a same-cycle consumption.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (!run)
            pend <= 1'b0;
        else
            pend <= (pend & ~taken) | set_pulse;
    end
endmodule

// File: rtl/pod_hold_timer.sv
module pod_hold_timer #(
    parameter int HOLD_TICKS = 8000,
    parameter int CNT_W      = $clog2(HOLD_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    input  logic             btn,
    input  logic             fire_taken,
    output logic             long_hit,
    output logic [CNT_W-1:0] cnt_o,
    output logic             was_o,
    output logic             spent_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             was_q;
    logic             spent_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            was_q <= 1'b0;
        end else if (!run || clr || !btn) begin
            cnt_q <= '0;
            was_q <= 1'b0;
        end else if (!was_q) begin
            cnt_q <= '0;
            was_q <= 1'b1;
        end else if (tick && !spent_q && (cnt_q < LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Set when a long press is reported; only a release clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            spent_q <= 1'b0;
        else if (!btn)
            spent_q <= 1'b0;
        else if (fire_taken)
            spent_q <= 1'b1;
    end

    assign long_hit = was_q && btn && !spent_q && !clr && (cnt_q == LIMIT);
    assign cnt_o    = cnt_q;
    assign was_o    = was_q;
    assign spent_o  = spent_q;
endmodule

// File: rtl/pod_cause_arb.sv
module pod_cause_arb
    import pod_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output cause_e             code,
    output logic               any
);
    logic [NUM_SRC-1:0] win;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
            if (i == 0) begin : g_top
                assign win[i] = req[i];
            end else begin : g_rest
                assign win[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        code = CAUSE_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win[i]) code = src_code(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/pwr_off_detect.sv
module pwr_off_detect
    import pod_pkg::*;
#(
    parameter int HOLD_TICKS = 8000,
    localparam int CNT_W     = $clog2(HOLD_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_on,
    input  logic       ms_tick,
    input  logic       btn_level,
    input  logic       ap_pgood,
    input  logic       off_req,
    input  logic       rst_req,
    input  logic       timer_clr,
    output logic [2:0] evt_cause,
    output logic       evt_valid
);
    fsm_e             state_q, state_d;
    cause_e           cause_q, cause_d;
    logic             valid_d;
    logic             armed;
    logic             off_pend;
    logic             long_hit;
    logic [CNT_W-1:0] hold_cnt;
    logic             was_pr;
    logic             spent;
    logic [NUM_SRC-1:0] src_req;
    cause_e           arb_code;
    logic             arb_any;
    logic             take_off;
    logic             take_long;

    assign armed = (state_q == ST_ARMED) && sys_on;

    pod_req_latch u_off (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (sys_on),
        .set_pulse (off_req),
        .taken     (take_off),
        .pend      (off_pend)
    );

    pod_hold_timer #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (sys_on),
        .clr        (timer_clr),
        .tick       (ms_tick),
        .btn        (btn_level),
        .fire_taken (take_long),
        .long_hit   (long_hit),
        .cnt_o      (hold_cnt),
        .was_o      (was_pr),
        .spent_o    (spent)
    );

    assign src_req = {~ap_pgood, long_hit, rst_req, off_pend};

    pod_cause_arb u_arb (
        .req  (src_req),
        .code (arb_code),
        .any  (arb_any)
    );

    assign take_off  = armed && arb_any && (arb_code == CAUSE_OFF_REQ);
    assign take_long = armed && arb_any && (arb_code == CAUSE_LONG);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!sys_on) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ARMED;
                ST_ARMED: if (arb_any) state_d = ST_FIRED;
                ST_FIRED: if (timer_clr) state_d = ST_ARMED;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output logic
    always_comb begin
        valid_d = 1'b0;
        cause_d = btn_level ? CAUSE_BUTTON : CAUSE_NONE;
        if (!sys_on) begin
            cause_d = CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ARMED: begin
                    if (arb_any) begin
                        valid_d = 1'b1;
                        cause_d = arb_code;
                    end
                end
                ST_FIRED: if (!timer_clr) cause_d = cause_q;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q   <= CAUSE_NONE;
            evt_valid <= 1'b0;
        end else begin
            cause_q   <= cause_d;
            evt_valid <= valid_d;
        end
    end

    assign evt_cause = cause_q;
endmodule

// File: rtl/pod_checker.sv
module pod_checker
    import pod_pkg::*;
#(
    parameter int HOLD_TICKS = 8000,
    parameter int CNT_W      = $clog2(HOLD_TICKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_on,
    input logic             timer_clr,
    input logic             ap_pgood,
    input logic             rst_req,
    input logic [2:0]       evt_cause,
    input logic             evt_valid,
    input fsm_e             state_q,
    input logic             off_pend,
    input logic [CNT_W-1:0] hold_cnt,
    input logic             was_pr
);
    p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

    p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_on |=> (!evt_valid && hold_cnt == '0 && evt_cause == 3'd0));

    p_code_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_cause >= 3'd2 && evt_cause <= 3'd5));

    p_off_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && sys_on && off_pend) |=> (evt_valid && evt_cause == 3'd4));

    p_reset_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && sys_on && !off_pend && rst_req) |=> (evt_valid && evt_cause == 3'd5));

    p_pg_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && sys_on && !ap_pgood) |=> evt_valid);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= CNT_W'(HOLD_TICKS));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_clr && sys_on) |=> (hold_cnt == '0 && !was_pr));
endmodule

bind pwr_off_detect pod_checker #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_on    (sys_on),
    .timer_clr (timer_clr),
    .ap_pgood  (ap_pgood),
    .rst_req   (rst_req),
    .evt_cause (evt_cause),
    .evt_valid (evt_valid),
    .state_q   (state_q),
    .off_pend  (off_pend),
    .hold_cnt  (hold_cnt),
    .was_pr    (was_pr)
);

// File: tb/sim_pwr_off_detect.sv
`timescale 1ns/1ps
module sim_pwr_off_detect;
    localparam int HOLD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, tk = 1'b0, bt = 1'b0, pg = 1'b1;
    logic       ro = 1'b0, rr = 1'b0, cl = 1'b0;
    logic [2:0] evt_cause;
    logic       evt_valid;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    int cycles = 0;
    int seed_dummy;

    // Reference state, written from the requirements
    int m_state;  // 0 idle, 1 armed, 2 fired
    bit m_off, m_was, m_spent, m_valid;
    int m_cnt, m_cause;

    always #2.5 clk = ~clk;

    pwr_off_detect #(.HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_on(en), .ms_tick(tk), .btn_level(bt),
        .ap_pgood(pg), .off_req(ro), .rst_req(rr), .timer_clr(cl),
        .evt_cause(evt_cause), .evt_valid(evt_valid)
    );

    always @(negedge clk) if (rst_n && evt_valid) n_pulse++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: act=%0d exp=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick_code(input bit long_hit);
        if (m_off)   return 4;     // R8 order
        if (rr)      return 5;
        if (long_hit) return 2;
        if (!pg)     return 3;
        return 0;
    endfunction

    task automatic model_step();
        bit lh, ev;
        int code;
        lh   = m_was && bt && (m_cnt == HOLD) && !m_spent && !cl;
        code = pick_code(lh);
        ev   = (m_state == 1) && en && (code != 0);
        m_valid = ev;
        if (!en)                        m_cause = 0;
        else if (ev)                    m_cause = code;
        else if (m_state == 2 && !cl)   m_cause = m_cause;
        else                            m_cause = bt ? 1 : 0;
        if (!bt)                        m_spent = 0;
        else if (ev && code == 2)       m_spent = 1;
        if (!en || cl || !bt) begin m_was = 0; m_cnt = 0; end
        else if (!m_was)      begin m_was = 1; m_cnt = 0; end
        else if (tk && !m_spent && m_cnt < HOLD) m_cnt++;
        if (!en) m_off = 0;
        else     m_off = (m_off && !(ev && code == 4)) || ro;
        if (!en)               m_state = 0;
        else if (m_state == 0) m_state = 1;
        else if (m_state == 1) m_state = ev ? 2 : 1;
        else                   m_state = cl ? 1 : 2;
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R9 valid", int'(evt_valid), int'(m_valid));
        chk("R12 cause", int'(evt_cause), m_cause);
    endtask

    task automatic rearm();
        cl = 1'b1; bt = 1'b0; step();
        cl = 1'b0; step();
    endtask

    initial begin
        int p0;
        m_state = 0; m_off = 0; m_was = 0; m_spent = 0; m_valid = 0; m_cnt = 0; m_cause = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(evt_valid), 0);
        chk("R1 cause", int'(evt_cause), 0);
        rst_n = 1'b1;
        tk = 1'b1;
        en = 1'b1; step(); step();

        // R2: long press
        bt = 1'b1;
        repeat (HOLD + 1) step();
        chk("R2 before", int'(evt_valid), 0);
        step();
        chk("R2 valid", int'(evt_valid), 1);
        chk("R2 cause", int'(evt_cause), 2);
        step();
        chk("R9 strobe", int'(evt_valid), 0);
        chk("R9 hold", int'(evt_cause), 2);

        // R4: held press does not fire again after clear
        cl = 1'b1; step(); cl = 1'b0;
        p0 = n_pulse;
        repeat (HOLD + 4) step();
        chk("R4 no refire", n_pulse - p0, 0);
        chk("R12 pressed", int'(evt_cause), 1);
        bt = 1'b0; step();
        bt = 1'b1;
        repeat (HOLD + 1) step();
        step();
        chk("R4 new press", int'(evt_cause), 2);
        rearm();

        // R3: release cancels
        p0 = n_pulse;
        bt = 1'b1; repeat (HOLD) step();
        bt = 1'b0; step();
        chk("R3 cancel", n_pulse - p0, 0);
        bt = 1'b1; repeat (HOLD + 1) step();
        chk("R3 restart", int'(evt_valid), 0);
        step();
        chk("R3 fire", int'(evt_cause), 2);
        rearm();

        // R10: clear restarts count while held
        bt = 1'b1; repeat (HOLD - 1) step();
        cl = 1'b1; step(); cl = 1'b0;
        repeat (HOLD + 1) step();
        chk("R10 after clr", int'(evt_valid), 0);
        step();
        chk("R10 fire", int'(evt_valid), 1);
        rearm();

        // R5: power-good lost
        pg = 1'b0; step();
        chk("R5 cause", int'(evt_cause), 3);
        pg = 1'b1; rearm();

        // R6: off request
        ro = 1'b1; step(); ro = 1'b0;
        chk("R6 latch", int'(evt_valid), 0);
        step();
        chk("R6 cause", int'(evt_cause), 4);
        rearm();
        p0 = n_pulse;
        repeat (3) step();
        chk("R6 consumed", n_pulse - p0, 0);

        // R7: reset request persists
        rr = 1'b1; step();
        chk("R7 first", int'(evt_cause), 5);
        cl = 1'b1; step(); cl = 1'b0; step();
        chk("R7 again", int'(evt_cause), 5);
        chk("R7 strobe", int'(evt_valid), 1);
        rr = 1'b0; rearm();

        // R8: priority
        ro = 1'b1; step(); ro = 1'b0; rr = 1'b1; pg = 1'b0;
        step();
        chk("R8 off wins", int'(evt_cause), 4);
        cl = 1'b1; step(); cl = 1'b0; step();
        chk("R8 reset over pg", int'(evt_cause), 5);
        rr = 1'b0; cl = 1'b1; step(); cl = 1'b0; step();
        chk("R8 pg last", int'(evt_cause), 3);
        pg = 1'b1; rearm();

        // R11: disabled
        en = 1'b0; step();
        p0 = n_pulse;
        pg = 1'b0; bt = 1'b1; ro = 1'b1; step(); ro = 1'b0;
        repeat (HOLD + 4) step();
        chk("R11 no event", n_pulse - p0, 0);
        chk("R11 cause", int'(evt_cause), 0);
        pg = 1'b1; bt = 1'b0; en = 1'b1; step(); step();
        chk("R11 off dropped", n_pulse - p0, 0);

        // Random phase, fixed seed
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 199) == 0) en = ~en;
            tk = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 19) == 0) bt = ~bt;
            pg = ($urandom_range(0, 199) != 0);
            ro = ($urandom_range(0, 99) == 0);
            if ($urandom_range(0, 299) == 0) rr = ~rr;
            cl = ($urandom_range(0, 29) == 0);
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule